// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding with ECC Qualification

This block sits in the decode stage of a short in-order pipeline. For each of two source operands it picks either the register file read data or the result that the writeback stage is writing in the same cycle. It also turns the per-port ECC error flags from the register file into one integrity alert. The alert drives an abort of execution outside this block.

When a load is still outstanding in writeback and an enabled read port needs the register that the load will write, the block raises a stall. An ECC error on a port is suppressed only when that port actually takes the forwarded value. An address match alone does not suppress it. A stalled load-use hazard, where the writeback stage is not writing and the operand comes from the register file, still reports a corrupted register file word.

The ECC encoder and decoder, the register array and the alert handler lie outside the block. The block matches each read address against the writeback destination itself.

Top module: `opfwd_ecc_gate`

## Requirements
- R1: An operand equals the writeback data when all four of these hold in the same cycle: its read address equals the writeback destination, the address is non-zero, writeback-valid is high, and writeback-write is high.
- R2: In every other case, the operand equals that port's register file read data. This includes a cycle where the address matches but writeback-write is low.
- R3: A read of register 0 never selects the writeback data and never causes a stall, whatever the writeback destination, valid and load flags are.
- R4: If an enabled port takes register file data and any bit of its ECC error vector is set, the alert is high in the cycle after the next rising clock edge.
- R5: A port that takes the writeback data (R1) contributes nothing to the alert, even when its ECC error bits are set.
- R6: ECC error bits on a port whose read enable is low have no effect on the alert.
- R7: The alert is the OR of the two qualified port errors. Masking on one port never hides an error on the other port.
- R8: The stall is high in the same cycle exactly when all of the following hold for at least one port: the outstanding-load flag is high, writeback-valid is high, the port is enabled, and its non-zero read address equals the writeback destination.
- R9: During a load-use stall with writeback-write low, the stalled port takes register file data, and an ECC error on that port raises the alert.
- R10: While reset is asserted, and in the first cycle after it, the alert is low.
- R11: With writeback-valid low, no port forwards and no stall is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_a_i | input | AW | Port A read address |
| rd_en_a_i | input | 1 | Port A read enable |
| rf_data_a_i | input | XLEN | Port A register file read data |
| rf_ecc_a_i | input | EW | Port A ECC error flags |
| rd_addr_b_i | input | AW | Port B read address |
| rd_en_b_i | input | 1 | Port B read enable |
| rf_data_b_i | input | XLEN | Port B register file read data |
| rf_ecc_b_i | input | EW | Port B ECC error flags |
| wb_dest_i | input | AW | Writeback destination register |
| wb_valid_i | input | 1 | Writeback stage holds an instruction |
| wb_write_i | input | 1 | Writeback stage writes this cycle |
| wb_load_pend_i | input | 1 | Writeback holds a load still waiting for data |
| wb_data_i | input | XLEN | Writeback result for forwarding |
| op_a_o | output | XLEN | Selected operand A |
| op_b_o | output | XLEN | Selected operand B |
| stall_o | output | 1 | Load-use hazard stall |
| alert_o | output | 1 | Registered integrity alert |

## Verification
The hardest case to reach is the stall cycle. In that cycle the read address still matches the writeback destination, but writeback-write is low, so the operand silently falls back to the register file. A design that masks on the address match alone hides a corrupted word exactly there. Directed sequences build this load-use state on each port in turn, with one ECC flag bit set. They then repeat the same state with writeback-write high, so the same error must be masked. Random stimulus draws addresses from a narrow range so that matches, register 0 and two-port mixes occur often.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

   typedef enum logic {
      SRC_RF = 1'b0,
      SRC_WB = 1'b1
   } opsrc_e;

   localparam int unsigned NPORT = 2;

endpackage

// File: rtl/opfwd_match.sv
module opfwd_match #(
   parameter int unsigned AW = 5
) (
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] dest_i,
   input  logic          valid_i,
   output logic          match_o
);
   logic nonzero;

   assign nonzero = |addr_i;
   assign match_o = valid_i & nonzero & (addr_i == dest_i);
endmodule

// File: rtl/opfwd_port.sv
module opfwd_port
   import opfwd_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned AW   = 5,
   parameter int unsigned EW   = 7
) (
   input  logic [AW-1:0]   addr_i,
   input  logic            en_i,
   input  logic [XLEN-1:0] rf_data_i,
   input  logic [EW-1:0]   ecc_i,
   input  logic [AW-1:0]   wb_dest_i,
   input  logic            wb_valid_i,
   input  logic            wb_write_i,
   input  logic            load_pend_i,
   input  logic [XLEN-1:0] wb_data_i,
   output logic [XLEN-1:0] op_o,
   output logic            err_o,
   output logic            hazard_o
);
   logic   match;
   opsrc_e src;

   opfwd_match #(.AW(AW)) u_match (
      .addr_i  (addr_i),
      .dest_i  (wb_dest_i),
      .valid_i (wb_valid_i),
      .match_o (match)
   );

   // Forwarding is in use only when the writeback stage really writes.
   always_comb begin
      src = SRC_RF;
      if (match && wb_write_i) begin
         src = SRC_WB;
      end
   end

   assign op_o = (src == SRC_WB) ? wb_data_i : rf_data_i;

   // Mask on consumption of the forwarded value, not on address match.
   assign err_o    = (|ecc_i) & en_i & (src == SRC_RF);
   assign hazard_o = match & en_i & load_pend_i;
endmodule

// File: rtl/opfwd_alert.sv
module opfwd_alert #(
   parameter int unsigned N   = 2,
   parameter bit          REG = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] err_i,
   output logic         alert_o
);
   logic any_err;

   assign any_err = |err_i;

   if (REG) begin : g_reg
      logic alert_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            alert_q <= 1'b0;
         end else begin
            alert_q <= any_err;
         end
      end
      assign alert_o = alert_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign alert_o    = any_err;
   end
endmodule

// File: rtl/opfwd_ecc_gate.sv
module opfwd_ecc_gate
   import opfwd_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned AW        = 5,
   parameter int unsigned EW        = 7,
   parameter bit          ALERT_REG = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [AW-1:0]   rd_addr_a_i,
   input  logic            rd_en_a_i,
   input  logic [XLEN-1:0] rf_data_a_i,
   input  logic [EW-1:0]   rf_ecc_a_i,
   input  logic [AW-1:0]   rd_addr_b_i,
   input  logic            rd_en_b_i,
   input  logic [XLEN-1:0] rf_data_b_i,
   input  logic [EW-1:0]   rf_ecc_b_i,
   input  logic [AW-1:0]   wb_dest_i,
   input  logic            wb_valid_i,
   input  logic            wb_write_i,
   input  logic            wb_load_pend_i,
   input  logic [XLEN-1:0] wb_data_i,
   output logic [XLEN-1:0] op_a_o,
   output logic [XLEN-1:0] op_b_o,
   output logic            stall_o,
   output logic            alert_o
);
   if (XLEN < 1) begin : g_bad_xlen
      $error("XLEN must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("AW must be at least 1");
   end
   if (EW < 1) begin : g_bad_ew
      $error("EW must be at least 1");
   end

   logic [AW-1:0]   addr   [NPORT];
   logic            en     [NPORT];
   logic [XLEN-1:0] rdata  [NPORT];
   logic [EW-1:0]   ecc    [NPORT];
   logic [XLEN-1:0] op     [NPORT];
   logic [NPORT-1:0] err;
   logic [NPORT-1:0] hazard;

   assign addr[0]  = rd_addr_a_i;
   assign addr[1]  = rd_addr_b_i;
   assign en[0]    = rd_en_a_i;
   assign en[1]    = rd_en_b_i;
   assign rdata[0] = rf_data_a_i;
   assign rdata[1] = rf_data_b_i;
   assign ecc[0]   = rf_ecc_a_i;
   assign ecc[1]   = rf_ecc_b_i;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      opfwd_port #(.XLEN(XLEN), .AW(AW), .EW(EW)) u_port (
         .addr_i      (addr[p]),
         .en_i        (en[p]),
         .rf_data_i   (rdata[p]),
         .ecc_i       (ecc[p]),
         .wb_dest_i   (wb_dest_i),
         .wb_valid_i  (wb_valid_i),
         .wb_write_i  (wb_write_i),
         .load_pend_i (wb_load_pend_i),
         .wb_data_i   (wb_data_i),
         .op_o        (op[p]),
         .err_o       (err[p]),
         .hazard_o    (hazard[p])
      );
   end

   assign op_a_o  = op[0];
   assign op_b_o  = op[1];
   assign stall_o = |hazard;

   opfwd_alert #(.N(NPORT), .REG(ALERT_REG)) u_alert (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .err_i   (err),
      .alert_o (alert_o)
   );
endmodule

// File: rtl/opfwd_ecc_gate_chk.sv
module opfwd_ecc_gate_chk #(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned AW        = 5,
   parameter int unsigned EW        = 7,
   parameter bit          ALERT_REG = 1'b1
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic [AW-1:0]   rd_addr_a_i,
   input logic            rd_en_a_i,
   input logic [XLEN-1:0] rf_data_a_i,
   input logic [EW-1:0]   rf_ecc_a_i,
   input logic [AW-1:0]   rd_addr_b_i,
   input logic            rd_en_b_i,
   input logic [XLEN-1:0] rf_data_b_i,
   input logic [EW-1:0]   rf_ecc_b_i,
   input logic [AW-1:0]   wb_dest_i,
   input logic            wb_valid_i,
   input logic            wb_write_i,
   input logic            wb_load_pend_i,
   input logic [XLEN-1:0] wb_data_i,
   input logic [XLEN-1:0] op_a_o,
   input logic [XLEN-1:0] op_b_o,
   input logic            stall_o,
   input logic            alert_o
);
   logic hit_a, hit_b;
   assign hit_a = wb_valid_i && (rd_addr_a_i == wb_dest_i) && (rd_addr_a_i != '0);
   assign hit_b = wb_valid_i && (rd_addr_b_i == wb_dest_i) && (rd_addr_b_i != '0);

   AST_FWD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_a && wb_write_i) |-> (op_a_o == wb_data_i)); // R1
   AST_FWD_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_b && wb_write_i) |-> (op_b_o == wb_data_i)); // R1
   AST_RF_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hit_a && wb_write_i) |-> (op_a_o == rf_data_a_i)); // R2
   AST_ZERO_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_addr_a_i == '0 && rd_addr_b_i == '0) |-> !stall_o); // R3
   AST_STALL_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wb_load_pend_i |-> !stall_o); // R8
   AST_NO_VALID_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wb_valid_i |-> !stall_o); // R11

   if (ALERT_REG) begin : g_seq
      AST_RF_ERR_ALERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rd_en_a_i && (|rf_ecc_a_i) && !(hit_a && wb_write_i)) |=> alert_o); // R4
      AST_FWD_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ((!rd_en_a_i || (hit_a && wb_write_i) || rf_ecc_a_i == '0) &&
          (!rd_en_b_i || (hit_b && wb_write_i) || rf_ecc_b_i == '0)) |=> !alert_o); // R5
      AST_HAZARD_RF_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (stall_o && !wb_write_i && rd_en_b_i && hit_b && (|rf_ecc_b_i)) |=> alert_o); // R9
   end
endmodule

bind opfwd_ecc_gate opfwd_ecc_gate_chk #(
   .XLEN(XLEN), .AW(AW), .EW(EW), .ALERT_REG(ALERT_REG)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .rd_addr_a_i    (rd_addr_a_i),
   .rd_en_a_i      (rd_en_a_i),
   .rf_data_a_i    (rf_data_a_i),
   .rf_ecc_a_i     (rf_ecc_a_i),
   .rd_addr_b_i    (rd_addr_b_i),
   .rd_en_b_i      (rd_en_b_i),
   .rf_data_b_i    (rf_data_b_i),
   .rf_ecc_b_i     (rf_ecc_b_i),
   .wb_dest_i      (wb_dest_i),
   .wb_valid_i     (wb_valid_i),
   .wb_write_i     (wb_write_i),
   .wb_load_pend_i (wb_load_pend_i),
   .wb_data_i      (wb_data_i),
   .op_a_o         (op_a_o),
   .op_b_o         (op_b_o),
   .stall_o        (stall_o),
   .alert_o        (alert_o)
);

// File: tb/opfwd_ecc_gate_test.sv
module opfwd_ecc_gate_test;
   localparam int unsigned XLEN = 32;
   localparam int unsigned AW   = 5;
   localparam int unsigned EW   = 7;

   logic            clk = 1'b0;
   logic            rst_ni = 1'b0;
   logic [AW-1:0]   rd_addr_a = '0, rd_addr_b = '0, wb_dest = '0;
   logic            rd_en_a = 1'b0, rd_en_b = 1'b0;
   logic [XLEN-1:0] rf_data_a = '0, rf_data_b = '0, wb_data = '0;
   logic [EW-1:0]   rf_ecc_a = '0, rf_ecc_b = '0;
   logic            wb_valid = 1'b0, wb_write = 1'b0, wb_load_pend = 1'b0;
   logic [XLEN-1:0] op_a, op_b;
   logic            stall, alert;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   opfwd_ecc_gate uut (
      .clk_i(clk), .rst_ni(rst_ni),
      .rd_addr_a_i(rd_addr_a), .rd_en_a_i(rd_en_a), .rf_data_a_i(rf_data_a), .rf_ecc_a_i(rf_ecc_a),
      .rd_addr_b_i(rd_addr_b), .rd_en_b_i(rd_en_b), .rf_data_b_i(rf_data_b), .rf_ecc_b_i(rf_ecc_b),
      .wb_dest_i(wb_dest), .wb_valid_i(wb_valid), .wb_write_i(wb_write),
      .wb_load_pend_i(wb_load_pend), .wb_data_i(wb_data),
      .op_a_o(op_a), .op_b_o(op_b), .stall_o(stall), .alert_o(alert)
   );

   function automatic bit m_hit(logic [AW-1:0] a);
      return wb_valid && (a != '0) && (a == wb_dest);
   endfunction

   function automatic bit m_fwd(logic [AW-1:0] a);
      return m_hit(a) && wb_write;
   endfunction

   function automatic bit m_err(logic [AW-1:0] a, logic en, logic [EW-1:0] e);
      return en && (e != '0) && !m_fwd(a);
   endfunction

   task automatic chk(bit ok, string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Inputs are set after a falling edge; outputs are checked away from edges.
   task automatic step(string req);
      logic [XLEN-1:0] ea, eb;
      bit es, ealert;
      #2;
      ea = m_fwd(rd_addr_a) ? wb_data : rf_data_a;
      eb = m_fwd(rd_addr_b) ? wb_data : rf_data_b;
      es = wb_load_pend && ((rd_en_a && m_hit(rd_addr_a)) || (rd_en_b && m_hit(rd_addr_b)));
      ealert = m_err(rd_addr_a, rd_en_a, rf_ecc_a) || m_err(rd_addr_b, rd_en_b, rf_ecc_b);
      chk(op_a == ea, {req, " R1/R2 op_a"}, op_a, ea);
      chk(op_b == eb, {req, " R1/R2 op_b"}, op_b, eb);
      chk(stall == es, {req, " R8 stall"}, {31'd0, stall}, {31'd0, es});
      @(posedge clk);
      #2;
      chk(alert == ealert, {req, " R4/R7 alert"}, {31'd0, alert}, {31'd0, ealert});
      @(negedge clk);
   endtask

   task automatic idle();
      rd_en_a = 0; rd_en_b = 0; rf_ecc_a = '0; rf_ecc_b = '0;
      wb_valid = 0; wb_write = 0; wb_load_pend = 0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240715));
      // R10: alert held low through reset even with errors present
      rd_en_a = 1; rf_ecc_a = 7'h01;
      repeat (3) @(negedge clk);
      chk(alert == 1'b0, "R10 alert in reset", {31'd0, alert}, 32'd0);
      idle();
      rst_ni = 1'b1;
      @(posedge clk); #2;
      chk(alert == 1'b0, "R10 alert after reset", {31'd0, alert}, 32'd0);
      @(negedge clk);

      rf_data_a = 32'hAAAA_0001; rf_data_b = 32'hBBBB_0002; wb_data = 32'hCAFE_F00D;

      // R9: load-use stall, writeback not writing, port A reads corrupt RF word
      rd_addr_a = 5'd4; rd_en_a = 1; rf_ecc_a = 7'h08;
      wb_dest = 5'd4; wb_valid = 1; wb_write = 0; wb_load_pend = 1;
      step("R9 port A");
      chk(stall == 1'b1, "R9 stall present", {31'd0, stall}, 32'd1);
      // R5: same state, writeback writes, error masked
      wb_write = 1; wb_load_pend = 0;
      step("R5 port A");
      chk(alert == 1'b0, "R5 masked", {31'd0, alert}, 32'd0);
      idle();

      // R9 on port B
      rd_addr_b = 5'd9; rd_en_b = 1; rf_ecc_b = 7'h40;
      wb_dest = 5'd9; wb_valid = 1; wb_write = 0; wb_load_pend = 1;
      step("R9 port B");
      // R7: A forwarded with error, B RF with error
      rd_addr_a = 5'd9; rd_en_a = 1; rf_ecc_a = 7'h01; rd_addr_b = 5'd3;
      wb_write = 1; wb_load_pend = 0;
      step("R7 mixed ports");
      chk(alert == 1'b1, "R7 B not hidden", {31'd0, alert}, 32'd1);
      idle();

      // R3: register 0 never forwards or stalls
      rd_addr_a = '0; rd_addr_b = '0; rd_en_a = 1; rd_en_b = 1;
      wb_dest = '0; wb_valid = 1; wb_write = 1; wb_load_pend = 1;
      step("R3 x0");
      chk(op_a == rf_data_a, "R3 op_a rf", op_a, rf_data_a);
      idle();

      // R6: error on disabled port ignored
      rd_addr_a = 5'd7; rd_en_a = 0; rf_ecc_a = 7'h7f;
      step("R6 disabled");
      chk(alert == 1'b0, "R6 alert", {31'd0, alert}, 32'd0);

      // R11: writeback invalid
      rd_en_a = 1; rf_ecc_a = '0; wb_dest = 5'd7; wb_valid = 0; wb_write = 1; wb_load_pend = 1;
      step("R11 invalid");
      chk(stall == 1'b0, "R11 stall", {31'd0, stall}, 32'd0);
      idle();

      // Random mix with a narrow address range
      for (int i = 0; i < 400; i++) begin
         rd_addr_a    = AW'($urandom_range(0, 3));
         rd_addr_b    = AW'($urandom_range(0, 3));
         wb_dest      = AW'($urandom_range(0, 3));
         rd_en_a      = $urandom_range(0, 3) != 0;
         rd_en_b      = $urandom_range(0, 3) != 0;
         wb_valid     = $urandom_range(0, 3) != 0;
         wb_write     = $urandom_range(0, 1) != 0;
         wb_load_pend = $urandom_range(0, 1) != 0;
         rf_ecc_a     = ($urandom_range(0, 2) == 0) ? EW'(1 << $urandom_range(0, EW - 1)) : '0;
         rf_ecc_b     = ($urandom_range(0, 2) == 0) ? EW'(1 << $urandom_range(0, EW - 1)) : '0;
         rf_data_a    = $urandom;
         rf_data_b    = $urandom;
         wb_data      = $urandom;
         step("random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule